// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control sequencer of a successive-approximation analog-to-digital converter. It runs on the system clock. A one-cycle conversion-clock enable, `tad_tick`, marks each conversion clock period (one TAD), and every timed step advances on that enable. Software requests a conversion with `start_set`. The block may first hold the sample switch closed for an automatic acquisition time, chosen by a 3-bit code. It then opens the switch and resolves the result one bit per TAD, from the most significant bit down. At each bit it drives a trial code to the capacitor DAC and reads the comparator's decision. The final conversion period discharges the capacitor array.

When a conversion finishes, the block loads the result into a pair of byte-wide result registers, drops busy and raises a sticky interrupt flag. Software may abort a running conversion with `stop_clr`, and dropping `enable` also aborts it. After an abort the previous result is kept. Every completion or abort is followed by a fixed recovery wait. Start requests are ignored during that wait, and the sample switch then closes again so that the input is tracked until the next request. While the block is not busy, software may also write the result registers directly.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low: `busy`=0, `irq`=0, `sample_closed`=1, `discharge`=0, `res_hi`=0 and `res_lo`=0.
- R2: A start is accepted only when the block is idle, `enable` is 1 and `stop_clr` is 0. `busy` is 1 from the clock edge that samples `start_set`. With acquisition code 000 the conversion starts at that same edge, so `sample_closed` is 0 from that edge on.
- R3: The automatic acquisition time, in TAD, is 0 for code 000, 2 for 001, 4 for 010, 6 for 011, 8 for 100, 12 for 101, 16 for 110 and 20 for 111. `sample_closed` stays 1 while acquiring. `busy` lasts for the acquisition time plus 11 TAD.
- R4: The conversion resolves bits 9 down to 0, one per TAD. The trial code on `dac_code` has the bit under test set, and `comp_in`=1 keeps that bit. With an ideal comparator (`comp_in` = input ≥ `dac_code`) the result equals the input.
- R5: On the TAD after the 11th conversion TAD, the result is loaded, `busy` falls and `irq` is set. `irq` stays 1 until a cycle with `irq_clr`=1 and no new completion.
- R6: `stop_clr`=1, or `enable`=0, while busy aborts the conversion: `busy` is 0 after the next edge, the result registers keep their value and `irq` is not set.
- R7: After a completion or an abort, a recovery wait of 2 TAD follows. A start sampled during that wait is ignored. A start sampled on the first edge after the wait is accepted.
- R8: `discharge` is 1 during the 11th conversion TAD, and during the whole recovery wait after an abort. `discharge` is never 1 while `sample_closed` is 1.
- R9: `start_set` is ignored while `enable` is 0.
- R10: The 10-bit result is right-justified: `res_hi` = {6'b0, result[9:8]} and `res_lo` = result[7:0].
- R11: While `busy` is 0, `wr_hi` loads `wr_data[1:0]` into result[9:8] and `wr_lo` loads `wr_data` into result[7:0]. Both writes are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tad_tick | input | 1 | One-cycle enable marking a conversion clock period |
| enable | input | 1 | Converter powered on |
| acq_sel | input | 3 | Automatic acquisition time code |
| start_set | input | 1 | Software request to start a conversion |
| stop_clr | input | 1 | Software request to abort a conversion |
| irq_clr | input | 1 | Clears the interrupt flag |
| comp_in | input | 1 | Comparator decision: input ≥ trial code |
| wr_hi | input | 1 | Software write of the high result byte |
| wr_lo | input | 1 | Software write of the low result byte |
| wr_data | input | 8 | Software write data |
| busy | output | 1 | Acquisition or conversion in progress |
| sample_closed | output | 1 | Sample switch closed (holding capacitor on input) |
| discharge | output | 1 | Capacitor array discharge control |
| dac_code | output | 10 | Trial code driven to the capacitor DAC |
| irq | output | 1 | Sticky conversion-complete flag |
| res_hi | output | 8 | High result byte, right-justified |
| res_lo | output | 8 | Low result byte |

## Verification
The bench builds the block with its default parameters: a 10-bit result and a 2-TAD recovery wait. The default width puts both byte boundaries of the right-justified result within reach, and the bench models an ideal comparator so that every input value resolves to itself. Most runs drive `tad_tick` on every clock, which turns each acquisition code and the recovery wait into exact cycle counts. One run divides the tick by three to show that only the enable paces the steps.

// File: rtl/sar_seq_pkg.sv
// Package: shared state encoding and the acquisition-time lookup for the
// conversion sequencer. Assumes a 3-bit acquisition select code.
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_CONV  = 2'd2,
        ST_RECOV = 2'd3
    } seq_state_t;

    localparam int ACQ_SEL_W = 3;
    localparam int ACQ_MAX   = 20;

    // Maps the acquisition select code to a TAD count.
    function automatic int unsigned acq_tad(input logic [ACQ_SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 0;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 12;
            3'd6:    return 16;
            default: return 20;
        endcase
    endfunction

endpackage

// File: rtl/sar_tad_timer.sv
// Module: down-counter in TAD units, shared by the acquisition and recovery
// phases. A load takes priority over counting. `last` flags the final TAD.
// Assumes the owner acts on `last` only together with `tick`.
module sar_tad_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Loads a new period or counts one TAD down, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sar_bit_engine.sv
// Module: successive-approximation register. On `init` it sets the trial
// code to the MSB. Each `advance` keeps or drops the bit under test from
// the comparator, then sets the next lower bit. `resolved` rises once every
// bit is decided. Assumes the owner stops advancing after `resolved`.
module sar_bit_engine #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init,
    input  logic                advance,
    input  logic                comp_in,
    output logic [RES_BITS-1:0] code,
    output logic                resolved
);
    localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] code_q;
    logic [RES_BITS-1:0] mask_q;

    // Steps the bit under test from MSB towards LSB, one per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (init) begin
            code_q <= MSB_ONE;
            mask_q <= MSB_ONE;
        end else if (advance && mask_q != '0) begin
            code_q <= (comp_in ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
            mask_q <= mask_q >> 1;
        end
    end

    assign code     = code_q;
    assign resolved = (mask_q == '0);

    // R4: at most one bit is under test at any time.
    assert_mask_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q));

endmodule

// File: rtl/sar_result_regs.sv
// Module: result register pair. A conversion load has priority over software
// writes. Software writes pass only when the owner allows them. The value is
// presented right-justified across two bytes. Assumes 9 <= RES_BITS <= 16.
module sar_result_regs #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_conv,
    input  logic [RES_BITS-1:0] conv_val,
    input  logic                wr_ok,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [7:0]          wr_data,
    output logic [7:0]          res_hi,
    output logic [7:0]          res_lo
);
    localparam int HI_W = RES_BITS - 8;

    logic [RES_BITS-1:0] val_q;

    // Takes a finished conversion or a permitted software byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (load_conv) begin
            val_q <= conv_val;
        end else if (wr_ok) begin
            if (wr_hi) val_q[RES_BITS-1:8] <= wr_data[HI_W-1:0];
            if (wr_lo) val_q[7:0]          <= wr_data;
        end
    end

    assign res_hi = 8'(val_q[RES_BITS-1:8]);
    assign res_lo = val_q[7:0];

endmodule

// File: rtl/sar_seq_ctrl.sv
// Module: top of the conversion sequencer. The state machine runs idle,
// optional acquisition, conversion (RES_BITS bit TADs plus one discharge
// TAD) and recovery. An abort from software or from a disable skips the
// result load. Assumes tad_tick is a one-cycle enable from an external
// divider and that comp_in is settled when tad_tick is sampled.
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int REC_TAD  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tad_tick,
    input  logic                enable,
    input  logic [2:0]          acq_sel,
    input  logic                start_set,
    input  logic                stop_clr,
    input  logic                irq_clr,
    input  logic                comp_in,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [7:0]          wr_data,
    output logic                busy,
    output logic                sample_closed,
    output logic                discharge,
    output logic [RES_BITS-1:0] dac_code,
    output logic                irq,
    output logic [7:0]          res_hi,
    output logic [7:0]          res_lo
);
    localparam int TMR_MAX = (ACQ_MAX > REC_TAD) ? ACQ_MAX : REC_TAD;
    localparam int CNT_W   = $clog2(TMR_MAX + 1);

    seq_state_t       state_q, state_d;
    logic             abort_rec_q, abort_rec_d;
    logic             irq_q;
    logic             tmr_load, tmr_last;
    logic [CNT_W-1:0] tmr_val;
    logic             eng_init, eng_adv, eng_done;
    logic             res_load, irq_set;
    logic             abort_req, start_ok;
    logic [CNT_W-1:0] acq_len;

    assign busy      = (state_q == ST_ACQ) || (state_q == ST_CONV);
    assign abort_req = busy && (stop_clr || !enable);
    assign start_ok  = (state_q == ST_IDLE) && enable && start_set && !stop_clr;
    assign acq_len   = CNT_W'(acq_tad(acq_sel));

    sar_tad_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tad_tick),
        .last     (tmr_last)
    );

    sar_bit_engine #(.RES_BITS(RES_BITS)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (eng_init),
        .advance  (eng_adv),
        .comp_in  (comp_in),
        .code     (dac_code),
        .resolved (eng_done)
    );

    sar_result_regs #(.RES_BITS(RES_BITS)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_conv (res_load),
        .conv_val  (dac_code),
        .wr_ok     (!busy),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wr_data   (wr_data),
        .res_hi    (res_hi),
        .res_lo    (res_lo)
    );

    // Next-state and control strobes of the sequencer.
    always_comb begin
        state_d     = state_q;
        abort_rec_d = abort_rec_q;
        tmr_load    = 1'b0;
        tmr_val     = CNT_W'(REC_TAD);
        eng_init    = 1'b0;
        eng_adv     = 1'b0;
        res_load    = 1'b0;
        irq_set     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    if (acq_len == '0) begin
                        state_d  = ST_CONV;
                        eng_init = 1'b1;
                    end else begin
                        state_d  = ST_ACQ;
                        tmr_load = 1'b1;
                        tmr_val  = acq_len;
                    end
                end
            end
            ST_ACQ: begin
                if (abort_req) begin
                    state_d     = ST_RECOV;
                    tmr_load    = 1'b1;
                    abort_rec_d = 1'b1;
                end else if (tad_tick && tmr_last) begin
                    state_d  = ST_CONV;
                    eng_init = 1'b1;
                end
            end
            ST_CONV: begin
                if (abort_req) begin
                    state_d     = ST_RECOV;
                    tmr_load    = 1'b1;
                    abort_rec_d = 1'b1;
                end else if (tad_tick) begin
                    if (eng_done) begin
                        state_d     = ST_RECOV;
                        tmr_load    = 1'b1;
                        abort_rec_d = 1'b0;
                        res_load    = 1'b1;
                        irq_set     = 1'b1;
                    end else begin
                        eng_adv = 1'b1;
                    end
                end
            end
            default: begin
                if (tad_tick && tmr_last)
                    state_d = ST_IDLE;
            end
        endcase
    end

    // State register and the abort-recovery marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            abort_rec_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            abort_rec_q <= abort_rec_d;
        end
    end

    // Sticky completion flag; a completion outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (irq_set)
            irq_q <= 1'b1;
        else if (irq_clr)
            irq_q <= 1'b0;
    end

    assign irq           = irq_q;
    assign sample_closed = !((state_q == ST_CONV) ||
                             (state_q == ST_RECOV && abort_rec_q));
    assign discharge     = (state_q == ST_CONV && eng_done) ||
                           (state_q == ST_RECOV && abort_rec_q);

    // R5: the last conversion TAD ends busy and raises the flag.
    assert_done_sets_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && eng_done && tad_tick && !stop_clr && enable)
        |=> (irq && !busy));

    // R6: an abort ends busy and leaves both result bytes untouched.
    assert_abort_keeps_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (stop_clr || !enable))
        |=> (!busy && $stable(res_hi) && $stable(res_lo)));

    // R7: a start during the recovery wait does not begin a conversion.
    assert_recov_blocks_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOV && start_set) |=> !busy);

    // R8: the array is never discharged while connected to the input.
    assert_discharge_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        discharge |-> !sample_closed);

    // R9: a disabled converter stays out of busy.
    assert_disabled_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !enable) |=> !busy);

endmodule

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tad_tick = 1'b1;
    logic       enable = 1'b1;
    logic [2:0] acq_sel = 3'd0;
    logic       start_set = 1'b0;
    logic       stop_clr = 1'b0;
    logic       irq_clr = 1'b0;
    logic       comp_in;
    logic       wr_hi = 1'b0;
    logic       wr_lo = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       busy, sample_closed, discharge, irq;
    logic [9:0] dac_code;
    logic [7:0] res_hi, res_lo;
    logic [9:0] vin = 10'h000;

    int checks = 0;
    int fails = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    int cycles = 0;
    int disch_seen = 0;

    // Stimulus table: input level per acquisition code, and expected busy TADs.
    localparam logic [9:0] VIN_T [8] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA,
                                         10'h200, 10'h1FF, 10'h001, 10'h0C7};
    localparam int LEN_T [8] = '{11, 13, 15, 17, 19, 23, 27, 31};

    always #2 clk = ~clk;

    // Ideal comparator.
    assign comp_in = (vin >= dac_code);

    sar_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tad_tick(tad_tick), .enable(enable),
        .acq_sel(acq_sel), .start_set(start_set), .stop_clr(stop_clr),
        .irq_clr(irq_clr), .comp_in(comp_in), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .busy(busy), .sample_closed(sample_closed),
        .discharge(discharge), .dac_code(dac_code), .irq(irq),
        .res_hi(res_hi), .res_lo(res_lo)
    );

    // Conversion clock enable, optionally divided.
    always @(negedge clk) begin
        tick_cnt = tick_cnt + 1;
        tad_tick <= (tick_div <= 1) ? 1'b1 : (tick_cnt % tick_div == 0);
        if (discharge) disch_seen = disch_seen + 1;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 100000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts a conversion and counts the negedges on which busy is high.
    task automatic run_conv(input logic [2:0] sel, input logic [9:0] v, output int n);
        acq_sel = sel;
        vin = v;
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        n = 0;
        disch_seen = 0;
        while (busy && n < 500) begin
            n = n + 1;
            @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (4 * ((tick_div < 1) ? 1 : tick_div)) @(negedge clk);
    endtask

    int n;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(busy == 0 && irq == 0, "R1 busy/irq after reset", {busy, irq}, 0);
        chk(sample_closed == 1 && discharge == 0, "R1 switch/discharge after reset",
            {sample_closed, discharge}, 2);
        chk(res_hi == 0 && res_lo == 0, "R1 result after reset", {res_hi, res_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: every acquisition code with a distinct input level.
        for (int i = 0; i < 8; i++) begin
            run_conv(3'(i), VIN_T[i], n);
            chk(n == LEN_T[i], "R3 busy length", n, LEN_T[i]);
            chk({res_hi[1:0], res_lo} == VIN_T[i], "R4 converted value",
                {res_hi[1:0], res_lo}, VIN_T[i]);
            chk(res_hi[7:2] == 0, "R10 upper bits of high byte", res_hi, 0);
            chk(disch_seen == 1, "R8 one discharge TAD per conversion", disch_seen, 1);
            chk(irq == 1, "R5 irq after completion", irq, 1);
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            chk(irq == 0, "R5 irq cleared", irq, 1'b0);
            settle();
        end

        // R2: code 000 opens the switch at the edge that takes the start.
        acq_sel = 3'd0; vin = 10'h2B4;
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        chk(busy == 1 && sample_closed == 0, "R2 immediate conversion start",
            {busy, sample_closed}, 2);
        while (busy) @(negedge clk);
        // R7: starts on the two recovery edges are ignored, the third is taken.
        start_set = 1'b1;
        @(negedge clk);
        chk(busy == 0, "R7 start ignored in recovery TAD 1", busy, 0);
        @(negedge clk);
        chk(busy == 0, "R7 start ignored in recovery TAD 2", busy, 0);
        @(negedge clk);
        start_set = 1'b0;
        chk(busy == 1, "R7 start accepted after recovery", busy, 1);
        while (busy) @(negedge clk);
        settle();

        // R3: acquisition keeps the switch closed.
        acq_sel = 3'd2;
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        chk(busy == 1 && sample_closed == 1, "R3 switch closed while acquiring",
            {busy, sample_closed}, 3);
        while (busy) @(negedge clk);
        settle();

        // R6: abort keeps the old result, no irq, recovery discharges.
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        run_conv(3'd0, 10'h1A5, n);
        settle();
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        acq_sel = 3'd0; vin = 10'h3C3;
        start_set = 1'b1; @(negedge clk); start_set = 1'b0;
        repeat (4) @(negedge clk);
        stop_clr = 1'b1; @(negedge clk); stop_clr = 1'b0;
        chk(busy == 0 && irq == 0, "R6 abort ends busy, no irq", {busy, irq}, 0);
        chk({res_hi[1:0], res_lo} == 10'h1A5, "R6 result kept on abort",
            {res_hi[1:0], res_lo}, 10'h1A5);
        chk(discharge == 1 && sample_closed == 0, "R8 discharge after abort",
            {discharge, sample_closed}, 2);
        @(negedge clk);
        chk(discharge == 1, "R8 discharge through recovery", discharge, 1);
        @(negedge clk);
        chk(discharge == 0 && sample_closed == 1, "R8 switch recloses after recovery",
            {discharge, sample_closed}, 1);
        settle();

        // R6: disabling mid-conversion also aborts.
        start_set = 1'b1; @(negedge clk); start_set = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b0; @(negedge clk);
        chk(busy == 0 && {res_hi[1:0], res_lo} == 10'h1A5, "R6 disable aborts",
            {busy, res_hi[1:0], res_lo}, 10'h1A5);
        settle();

        // R9: start while disabled is ignored.
        start_set = 1'b1; @(negedge clk); start_set = 1'b0;
        chk(busy == 0, "R9 start ignored while disabled", busy, 0);
        @(negedge clk);
        enable = 1'b1;
        settle();

        // R11 and R10: software writes when idle, right-justified.
        wr_hi = 1'b1; wr_data = 8'hFF; @(negedge clk); wr_hi = 1'b0;
        chk(res_hi == 8'h03, "R11 high write keeps two bits", res_hi, 8'h03);
        wr_lo = 1'b1; wr_data = 8'h5A; @(negedge clk); wr_lo = 1'b0;
        chk(res_lo == 8'h5A, "R11 low write", res_lo, 8'h5A);
        acq_sel = 3'd7;
        start_set = 1'b1; @(negedge clk); start_set = 1'b0;
        wr_lo = 1'b1; wr_hi = 1'b1; wr_data = 8'h00; @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0;
        chk(res_lo == 8'h5A && res_hi == 8'h03, "R11 writes ignored while busy",
            {res_hi, res_lo}, 16'h035A);
        stop_clr = 1'b1; @(negedge clk); stop_clr = 1'b0;
        settle();

        // R3/R4 with a tick every third clock.
        tick_div = 3;
        settle();
        run_conv(3'd1, 10'h2B7, n);
        chk(n >= 37 && n <= 39, "R3 slow tick busy length", n, 39);
        chk({res_hi[1:0], res_lo} == 10'h2B7, "R4 slow tick value",
            {res_hi[1:0], res_lo}, 10'h2B7);
        settle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule